// File: doc/BRIEF.md
# SPI Slave Byte Front End with Hold

This block is the serial edge of an SPI slave. A fast system clock oversamples the chip select, serial clock, serial input and hold pins. The block then turns the serial stream into whole received bytes, and it turns parallel transmit bytes back into a serial output. Both clock polarities that idle the serial clock low or high (SPI mode 0 and mode 3) are handled with the same logic. Input data is captured on serial-clock rising edges and the output moves only after falling edges. Bits travel most significant first. Each received byte is handed out with a one-cycle valid strobe and its position within the current select window.

Transmit bytes are taken from the `txData` input. The block loads it when the select window opens and again at the falling edge that follows every completed byte. A one-cycle `txTake` pulse marks each load, so the consumer can present the next byte before it is needed. An active-low hold input lets the master pause the transfer without closing the select window. Hold is entered and left only while the serial clock is low. While hold is active the output is released, clock and data are ignored, and the bit position is preserved.

Top module: `spi_hold_slave`

## Requirements
- R1: After reset, `soEn`, `rxValid` and `txTake` are all 0.
- R2: In mode 0 (clock idle low), eight rising edges in an open select window yield one `rxValid` pulse whose `rxByte` holds the bits in arrival order, first bit in bit 7. `rxIndex` is 0 for the first byte of a window and rises by one for each further byte.
- R3: In mode 3 (clock idle high), the falling edge that comes before the first rising edge shifts nothing, and bytes are received exactly as in R2.
- R4: `so` shows bit 7 of the byte loaded at the start of the window before the first rising edge. It advances one bit toward bit 0 after each later falling edge. At the falling edge after the eighth rising edge a new `txData` byte is loaded, and each load gives one `txTake` pulse.
- R5: If chip select rises before the eighth rising edge of a byte, no `rxValid` is given for that byte. The next window starts again at index 0 with a fresh byte on `so`.
- R6: `soEn` is 1 only while chip select is low and hold is not active.
- R7: If `holdN` falls while the serial clock is high, hold begins only when the clock next goes low. If it falls while the clock is low, hold begins at once.
- R8: During hold, serial-clock edges and `si` have no effect. After hold ends, `so` shows the same bit as before hold and the byte completes with the bits given outside hold.
- R9: If `holdN` rises while the serial clock is high, hold stays active until the clock is low. If it rises while the clock is low, hold ends at once.
- R10: Raising chip select during hold ends hold. The next window starts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select from the master |
| sck | input | 1 | Serial clock from the master |
| si | input | 1 | Serial data from the master |
| holdN | input | 1 | Active-low hold request |
| txData | input | DW | Next byte to transmit; sampled on each load |
| txTake | output | 1 | One-cycle pulse when `txData` has been loaded |
| rxValid | output | 1 | One-cycle pulse when a byte has been received |
| rxByte | output | DW | Received byte, valid with `rxValid` |
| rxIndex | output | IW | Position of the byte within the select window |
| so | output | 1 | Serial output data |
| soEn | output | 1 | Output enable for `so` (0 means high impedance) |

## Verification
The stimulus sends multi-byte windows in both clock polarities, with bit patterns of mixed ones and zeros, all zeros and all ones. This separates a wrong shift direction or bit order from a wrong byte count. A truncated byte followed by a new window checks that an abort leaves no stray byte and no stale index. Hold is applied with the pin falling both while the clock is high and while it is low, with junk clocks and data during the pause. Each case is checked for when the output enable drops and returns, and for which bit appears on the output after resume. A final case closes the window during hold.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;

  // Strobes sent from control to datapath, valid for one system clock.
  typedef struct packed {
    logic frameClr;    // select inactive: clear counters
    logic frameStart;  // select just opened: load first transmit byte
    logic shiftIn;     // accepted rising serial-clock edge
    logic shiftOut;    // accepted falling serial-clock edge (after a rise)
  } ctrl_strobe_t;

endpackage

// File: rtl/spi_hold_sync.sv
module spi_hold_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic stage1;
    logic stage2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stage1 <= RESET_VAL[g];
        stage2 <= RESET_VAL[g];
      end else begin
        stage1 <= asyncIn[g];
        stage2 <= stage1;
      end
    end
    assign syncOut[g] = stage2;
  end

endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl
  import spi_hold_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csSync,
  input  logic         sckSync,
  input  logic         holdSync,
  output ctrl_strobe_t st,
  output logic         soEn
);

  logic sckQ;
  logic csQ;
  logic holdState;
  logic holdNext;
  logic sawRise;
  logic csActive;
  logic sckRise;
  logic sckFall;
  logic gate;

  assign csActive = !csSync;
  assign sckRise  = !sckQ && sckSync;
  assign sckFall  = sckQ && !sckSync;
  assign gate     = csActive && !holdState;

  // Hold can change only while the serial clock is low.
  always_comb begin
    holdNext = holdState;
    if (!csActive)     holdNext = 1'b0;
    else if (!sckSync) holdNext = !holdSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ      <= 1'b0;
      csQ       <= 1'b1;
      holdState <= 1'b0;
      sawRise   <= 1'b0;
    end else begin
      sckQ      <= sckSync;
      csQ       <= csSync;
      holdState <= holdNext;
      if (!csActive)              sawRise <= 1'b0;
      else if (sckRise && gate)   sawRise <= 1'b1;
    end
  end

  always_comb begin
    st            = '0;
    st.frameClr   = !csActive;
    st.frameStart = csQ && !csSync;
    st.shiftIn    = sckRise && gate;
    st.shiftOut   = sckFall && gate && sawRise;
  end

  assign soEn = gate;

  AST_HOLD_ENTRY_SCKLOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdState) |-> $past(!sckSync));  // R7

  AST_HOLD_EXIT_SCKLOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdState) |-> ($past(!sckSync) || $past(csSync)));  // R9

  AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    holdState |-> (!st.shiftIn && !st.shiftOut));  // R8

  AST_CS_ENDS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    csSync |=> !holdState);  // R10

endmodule

// File: rtl/spi_hold_dp.sv
module spi_hold_dp
  import spi_hold_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrl_strobe_t  st,
  input  logic          siSync,
  input  logic [DW-1:0] txData,
  output logic          txTake,
  output logic          rxValid,
  output logic [DW-1:0] rxByte,
  output logic [IW-1:0] rxIndex,
  output logic          so
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(DW - 1);

  logic [CW-1:0] bitCnt;
  logic [IW-1:0] byteCnt;
  logic [DW-1:0] rxSh;
  logic [DW-1:0] txSh;
  logic [DW-1:0] rxNext;

  assign rxNext = {rxSh[DW-2:0], siSync};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      byteCnt <= '0;
      rxSh    <= '0;
      txSh    <= '0;
      rxValid <= 1'b0;
      rxByte  <= '0;
      rxIndex <= '0;
      txTake  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      txTake  <= 1'b0;
      if (st.frameClr) begin
        bitCnt  <= '0;
        byteCnt <= '0;
      end else begin
        if (st.frameStart) begin
          txSh   <= txData;
          txTake <= 1'b1;
        end
        if (st.shiftIn) begin
          rxSh <= rxNext;
          if (bitCnt == LAST_BIT) begin
            bitCnt  <= '0;
            rxValid <= 1'b1;
            rxByte  <= rxNext;
            rxIndex <= byteCnt;
            byteCnt <= byteCnt + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        if (st.shiftOut) begin
          if (bitCnt == '0) begin
            txSh   <= txData;
            txTake <= 1'b1;
          end else begin
            txSh <= {txSh[DW-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign so = txSh[DW-1];

  AST_RX_FROM_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(st.shiftIn));  // R2

  AST_TAKE_FROM_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    txTake |-> ($past(st.frameStart) || $past(st.shiftOut)));  // R4

  AST_NO_RX_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    st.frameClr |=> !rxValid);  // R5

endmodule

// File: rtl/spi_hold_slave.sv
module spi_hold_slave
  import spi_hold_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN,
  input  logic          sck,
  input  logic          si,
  input  logic          holdN,
  input  logic [DW-1:0] txData,
  output logic          txTake,
  output logic          rxValid,
  output logic [DW-1:0] rxByte,
  output logic [IW-1:0] rxIndex,
  output logic          so,
  output logic          soEn
);

  // Order: {holdN, si, sck, csN}; select and hold reset inactive.
  localparam logic [3:0] SYNC_RST = 4'b1001;

  logic [3:0]   syncVec;
  ctrl_strobe_t st;

  spi_hold_sync #(.W(4), .RESET_VAL(SYNC_RST)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({holdN, si, sck, csN}),
    .syncOut (syncVec)
  );

  spi_hold_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .csSync   (syncVec[0]),
    .sckSync  (syncVec[1]),
    .holdSync (syncVec[3]),
    .st       (st),
    .soEn     (soEn)
  );

  spi_hold_dp #(.DW(DW), .IW(IW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .siSync  (syncVec[2]),
    .txData  (txData),
    .txTake  (txTake),
    .rxValid (rxValid),
    .rxByte  (rxByte),
    .rxIndex (rxIndex),
    .so      (so)
  );

  AST_SOEN_NEEDS_CS: assert property (@(posedge clk) disable iff (!rstN)
    soEn |-> !syncVec[0]);  // R6

endmodule

// File: tb/spi_hold_slave_tb.sv
module spi_hold_slave_tb;

  localparam int DW = 8;
  localparam int IW = 8;
  localparam int H  = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          csN = 1'b1;
  logic          sck = 1'b0;
  logic          si = 1'b0;
  logic          holdN = 1'b1;
  logic [DW-1:0] txData = 8'h5C;
  logic          txTake;
  logic          rxValid;
  logic [DW-1:0] rxByte;
  logic [IW-1:0] rxIndex;
  logic          so;
  logic          soEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] curTx = '0;
  logic [IW+DW-1:0] expQ[$];

  always #4 clk = !clk;

  spi_hold_slave #(.DW(DW), .IW(IW)) u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .txData(txData), .txTake(txTake), .rxValid(rxValid), .rxByte(rxByte),
    .rxIndex(rxIndex), .so(so), .soEn(soEn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: scoreboard for received bytes, tracking of transmit loads.
  always @(negedge clk) begin
    if (rstN && txTake) begin
      curTx  = txData;
      txData = txData * 8'd5 + 8'h3B;
    end
    if (rstN && rxValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected byte", {rxIndex, rxByte}, 0);
      end else begin
        logic [IW+DW-1:0] e;
        e = expQ.pop_front();
        check({rxIndex, rxByte} == e, "R2/R3 byte and index", {rxIndex, rxByte}, e);
      end
    end
  end

  // Drive bits hi..lo of b; before each rising edge check so and soEn (R4, R6).
  task automatic sendRange(input logic [DW-1:0] b, input int hi, input int lo);
    for (int i = hi; i >= lo; i--) begin
      sck = 1'b0;
      si  = b[i];
      tick(H);
      check(so === curTx[i], "R4 so bit", so, curTx[i]);
      check(soEn === 1'b1, "R6 soEn active", soEn, 1);
      sck = 1'b1;
      tick(H);
    end
  endtask

  task automatic sendByte(input logic [DW-1:0] b, input int idx);
    expQ.push_back({IW'(idx), b});
    sendRange(b, DW - 1, 0);
  endtask

  task automatic openFrame(input bit mode3);
    sck = mode3;
    tick(H);
    csN = 1'b0;
    tick(H);
  endtask

  task automatic closeFrame();
    tick(H);
    csN = 1'b1;
    tick(H);
    check(soEn === 1'b0, "R6 soEn idle", soEn, 0);
  endtask

  initial begin
    tick(3);
    check(soEn === 1'b0 && rxValid === 1'b0 && txTake === 1'b0, "R1 reset outputs",
          {soEn, rxValid, txTake}, 0);
    rstN = 1'b1;
    tick(4);
    check(soEn === 1'b0, "R1 soEn after reset", soEn, 0);

    // R2 / R4: mode 0, three bytes.
    openFrame(1'b0);
    sendByte(8'hA5, 0);
    sendByte(8'h3C, 1);
    sendByte(8'hFF, 2);
    sck = 1'b0;
    closeFrame();

    // R3: mode 3, two bytes.
    openFrame(1'b1);
    sendByte(8'h00, 0);
    sendByte(8'h96, 1);
    closeFrame();

    // R5: abort after four bits, then a new window from index 0.
    openFrame(1'b0);
    sendRange(8'hF0, 7, 4);
    sck = 1'b0;
    closeFrame();
    openFrame(1'b0);
    sendByte(8'h81, 0);
    sck = 1'b0;
    closeFrame();

    // R7 / R8 / R9: hold requested while the clock is high.
    openFrame(1'b0);
    expQ.push_back({IW'(0), 8'h5A});
    sendRange(8'h5A, 7, 4);
    holdN = 1'b0;
    tick(H);
    check(soEn === 1'b1, "R7 no hold while clock high", soEn, 1);
    sck = 1'b0;
    tick(H);
    check(soEn === 1'b0, "R7 hold at clock low", soEn, 0);
    for (int k = 0; k < 3; k++) begin
      si = k[0];
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
      tick(H);
    end
    check(soEn === 1'b0, "R8 stays held", soEn, 0);
    sck = 1'b1;
    tick(H);
    holdN = 1'b1;
    tick(H);
    check(soEn === 1'b0, "R9 exit waits for clock low", soEn, 0);
    sck = 1'b0;
    tick(H);
    check(soEn === 1'b1, "R9 exit at clock low", soEn, 1);
    check(so === curTx[3], "R8 bit position kept", so, curTx[3]);
    sendRange(8'h5A, 3, 0);
    sck = 1'b0;
    closeFrame();

    // R7 / R8 / R9: hold requested while the clock is low, mode 3.
    openFrame(1'b1);
    expQ.push_back({IW'(0), 8'hC3});
    sendRange(8'hC3, 7, 6);
    sck = 1'b0;
    si  = 1'b0;
    tick(H);
    holdN = 1'b0;
    tick(H);
    check(soEn === 1'b0, "R7 immediate hold at clock low", soEn, 0);
    for (int k = 0; k < 2; k++) begin
      si = !k[0];
      sck = 1'b1;
      tick(H);
      sck = 1'b0;
      tick(H);
    end
    holdN = 1'b1;
    tick(H);
    check(soEn === 1'b1, "R9 immediate exit at clock low", soEn, 1);
    check(so === curTx[5], "R8 bit position kept", so, curTx[5]);
    sendRange(8'hC3, 5, 0);
    closeFrame();

    // R10: chip select raised during hold.
    openFrame(1'b0);
    sendRange(8'h11, 7, 5);
    holdN = 1'b0;
    sck = 1'b0;
    tick(H);
    check(soEn === 1'b0, "R10 held before release", soEn, 0);
    csN = 1'b1;
    tick(H);
    holdN = 1'b1;
    tick(H);
    check(soEn === 1'b0, "R10 standby after release", soEn, 0);
    openFrame(1'b0);
    sendByte(8'hE7, 0);
    sck = 1'b0;
    closeFrame();

    tick(H);
    check(expQ.size() == 0, "R2 all bytes received", expQ.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule